// File: doc/BRIEF.md
# Receive Byte Queue with Status Interleave

This block is the per-channel receive store that follows a serial deserializer. Each incoming character arrives on a valid/data/flags input together with its four error indications and two compare-hit indications. The character is held in a first-in first-out queue of `DEPTH` entries, 1023 by default. The host drains the queue through a 16-bit read port. It reads a channel status word that combines live line levels with error flags that stay set until the full word is read. It also sees a count of stored characters and a trigger output whose threshold it selects.

The read port has two formats. In packed mode one read removes up to two characters: the older one in the low byte, the newer one in the high byte. In interleaved status mode one read removes a single character and returns its error nibble in the high byte. The mode is held in bit 15 of the status word. A count-reset command discards everything queued.

Top module: `rxq_status_fifo`

## Requirements
- R1: After reset `rx_count` is 0, `rd_data` is 0, `trig_hit` is 0 and `stat_word` is 0 when all line-level inputs are low.
- R2: Characters leave in arrival order. `rx_count` equals the number stored and never exceeds `DEPTH`. Exactly `DEPTH` characters can be held.
- R3: A character offered while `rx_count == DEPTH` is discarded and the queue contents and count are unchanged. From the next cycle `stat_word` bit 13 (queue overflow) is set.
- R4: With `stat_word` bit 15 clear, a read returns the oldest character in bits 7:0 and the next one in bits 15:8, and removes both. With one character stored, it returns that character with bits 15:8 zero and removes it.
- R5: Writing `stat_wdata` with bit 15 set through `stat_wr` selects status mode, and bit 15 reads back as 1. In that mode a read returns the character in bits 7:0 and its error nibble in bits 11:8, with bits 15:12 zero, and removes one character. The nibble encoding is: break 0x08, framing 0x04, overrun 0x02, parity 0x01.
- R6: A read while the queue is empty returns 0x0000 and leaves `rx_count` unchanged.
- R7: Accepting a character sets sticky bits in `stat_word`: break sets bit 10 (0x0400), framing sets bit 9 (0x0200), parity sets bit 8 (0x0100), compare-1 hit sets bit 11 (0x0800) and compare-2 hit sets bit 12 (0x1000). A full-word status read (`stat_rd` with `stat_rd_word` high) clears bits 13:8 from the next cycle. A bit set in the same cycle as that read survives the clear.
- R8: The low byte of `stat_word` reports CTS 0x20, DSR 0x10, CD 0x08, Tx queue empty 0x04, Tx shifter empty 0x02, and 0x01 when `rx_count` is nonzero. A status read with `stat_rd_word` low leaves bits 13:8 unchanged.
- R9: `trig_sel` selects the threshold for `trig_hit`. 00 never asserts. 01 asserts at a count of at least 1. 10 asserts at a count of at least (DEPTH+1)/2, which is 512 by default. 11 asserts at a count of at least 7*(DEPTH+1)/8, which is 896 by default.
- R10: `cnt_reset` empties the queue: `rx_count` is 0 on the next cycle, a character offered in that cycle is discarded, and the next character accepted is the first one read out.
- R11: A read and an accepted character in the same cycle give a count of old count plus one minus the number removed. The new character is not part of that read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Received character strobe |
| in_data | input | 8 | Received character |
| in_flags | input | 4 | Error nibble: break, framing, overrun, parity (bits 3..0) |
| in_match | input | 2 | Compare hits: bit 0 compare-1, bit 1 compare-2 |
| cnt_reset | input | 1 | Discard queue contents and zero the count |
| rd_req | input | 1 | Read one word from the queue |
| rd_data | output | 16 | Word returned by the last read |
| rx_count | output | CW | Number of characters stored |
| trig_sel | input | 2 | Trigger threshold select |
| trig_hit | output | 1 | Count at or above the selected threshold |
| stat_wr | input | 1 | Status word write strobe (bit 15 is the mode) |
| stat_wdata | input | 16 | Status word write value |
| stat_rd | input | 1 | Status read strobe |
| stat_rd_word | input | 1 | High: full-word read, which clears sticky bits |
| stat_word | output | 16 | Channel status word |
| cts_in | input | 1 | CTS level |
| dsr_in | input | 1 | DSR level |
| cd_in | input | 1 | CD level |
| tx_fifo_empty | input | 1 | Transmit queue empty level |
| tx_shift_empty | input | 1 | Transmit shifter empty level |

## Verification
A pointer or count that drifts out of step shows up on the first read after it: characters come out of order, or a read returns zero while `rx_count` and the data-available bit claim a character is stored. A wrong fill level moves the edge of `trig_hit` by a count of one, so the thresholds are checked on both sides of each edge. A wrong wrap at a depth that is not a power of two only appears after the full capacity has been cycled through, so the queue is filled to the brim, overflowed and drained completely. Sticky-bit faults appear one cycle after the status read that should, or should not, have cleared them.

// File: rtl/rxq_pkg.sv
// Shared types and bit positions for the receive byte queue.
package rxq_pkg;
    // Per-character error nibble; bit order is the read-format encoding.
    typedef struct packed {
        logic brk;
        logic frm;
        logic ovr;
        logic par;
    } rxq_flags_t;

    localparam int FLAG_W  = 4;
    localparam int CHAR_W  = 8;
    localparam int ENTRY_W = FLAG_W + CHAR_W;

    // Trigger threshold selections.
    typedef enum logic [1:0] {
        TRIG_OFF  = 2'b00,
        TRIG_ONE  = 2'b01,
        TRIG_HALF = 2'b10,
        TRIG_7_8  = 2'b11
    } rxq_trig_e;

    // Sticky flag vector order (index into the sticky register).
    localparam int SK_PAR = 0;
    localparam int SK_FRM = 1;
    localparam int SK_BRK = 2;
    localparam int SK_M1  = 3;
    localparam int SK_M2  = 4;
    localparam int SK_OVF = 5;
    localparam int SK_W   = 6;
endpackage

// File: rtl/rxq_store.sv
// Circular character store of DEPTH entries with its own fill count.
// Assumes: the caller never pushes when full and never pops more than
// are stored; flush has priority over push and pop.
module rxq_store #(
    parameter int DEPTH = 1023,
    parameter int DW    = 12,
    localparam int PW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          push,
    input  logic [DW-1:0] push_word,
    input  logic [1:0]    pop_n,
    output logic [CW-1:0] count,
    output logic [DW-1:0] head0,
    output logic [DW-1:0] head1
);
    logic [DW-1:0] mem [DEPTH];
    logic [PW-1:0] wr_ptr;
    logic [PW-1:0] rd_ptr;

    // Advance a pointer by n with wrap at DEPTH (depth need not be 2^k).
    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p, input int n);
        int s;
        s = int'(p) + n;
        if (s >= DEPTH) s = s - DEPTH;
        return PW'(s);
    endfunction

    // Storage write port.
    always_ff @(posedge clk) begin
        if (push) mem[wr_ptr] <= push_word;
    end

    // Pointer and count maintenance.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) wr_ptr <= bump(wr_ptr, 1);
            rd_ptr <= bump(rd_ptr, int'(pop_n));
            count  <= count + CW'(push) - CW'(pop_n);
        end
    end

    // Oldest two entries, read without a clock.
    always_comb begin
        head0 = mem[rd_ptr];
        head1 = mem[bump(rd_ptr, 1)];
    end
endmodule

// File: rtl/rxq_trigger.sv
// Fill-level trigger: compares the count against the selected threshold.
// Assumes: count never exceeds DEPTH.
module rxq_trigger #(
    parameter int DEPTH = 1023,
    localparam int CW   = $clog2(DEPTH + 1),
    localparam int HALF = (DEPTH + 1) / 2,
    localparam int SEV8 = ((DEPTH + 1) * 7) / 8
) (
    input  logic [1:0]    sel,
    input  logic [CW-1:0] count,
    output logic          hit
);
    import rxq_pkg::*;

    // Threshold compare for the selected level.
    always_comb begin
        unique case (rxq_trig_e'(sel))
            TRIG_OFF:  hit = 1'b0;
            TRIG_ONE:  hit = (count != '0);
            TRIG_HALF: hit = (count >= CW'(HALF));
            TRIG_7_8:  hit = (count >= CW'(SEV8));
            default:   hit = 1'b0;
        endcase
    end
endmodule

// File: rtl/rxq_status.sv
// Channel status word: mode bit, sticky flags, live line levels.
// Assumes: set and clear may coincide; set wins for that bit.
module rxq_status
    import rxq_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            mode_wr,
    input  logic            mode_val,
    input  logic [SK_W-1:0] set_bits,
    input  logic            clr_sticky,
    input  logic [4:0]      levels,
    input  logic            rda,
    output logic            mode,
    output logic [15:0]     word
);
    logic [SK_W-1:0] sticky;

    // Read-format mode bit, written by the host.
    always_ff @(posedge clk) begin
        if (!rst_n)       mode <= 1'b0;
        else if (mode_wr) mode <= mode_val;
    end

    // Sticky flags: clear on full-word read, new events always land.
    always_ff @(posedge clk) begin
        if (!rst_n) sticky <= '0;
        else        sticky <= (clr_sticky ? '0 : sticky) | set_bits;
    end

    // Word assembly: bit 14 and bits 7:6 are reserved zero.
    always_comb begin
        word = {mode, 1'b0, sticky, 2'b00, levels, rda};
    end
endmodule

// File: rtl/rxq_status_fifo.sv
// Receive byte queue with packed or status-interleaved host reads.
// Assumes: one read per cycle; a character offered in the same cycle as
// a read is not visible to that read; rd_data holds until the next read.
module rxq_status_fifo #(
    parameter int DEPTH = 1023,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [7:0]    in_data,
    input  logic [3:0]    in_flags,
    input  logic [1:0]    in_match,
    input  logic          cnt_reset,
    input  logic          rd_req,
    output logic [15:0]   rd_data,
    output logic [CW-1:0] rx_count,
    input  logic [1:0]    trig_sel,
    output logic          trig_hit,
    input  logic          stat_wr,
    input  logic [15:0]   stat_wdata,
    input  logic          stat_rd,
    input  logic          stat_rd_word,
    output logic [15:0]   stat_word,
    input  logic          cts_in,
    input  logic          dsr_in,
    input  logic          cd_in,
    input  logic          tx_fifo_empty,
    input  logic          tx_shift_empty
);
    import rxq_pkg::*;

    logic                push_ok, push_drop, mode;
    logic [1:0]          pop_n;
    logic [ENTRY_W-1:0]  head0, head1;
    logic [15:0]         fmt;
    logic [SK_W-1:0]     set_bits;
    rxq_flags_t          fl;
    logic                full, empty;

    assign fl    = rxq_flags_t'(in_flags);
    assign full  = (rx_count == CW'(DEPTH));
    assign empty = (rx_count == '0);

    // Accept or drop the offered character.
    always_comb begin
        push_ok   = in_valid && !cnt_reset && !full;
        push_drop = in_valid && !cnt_reset && full;
    end

    // Characters removed by this read, from the count before the push.
    always_comb begin
        if (!rd_req || cnt_reset || empty) pop_n = 2'd0;
        else if (mode)                     pop_n = 2'd1;
        else if (rx_count >= CW'(2))       pop_n = 2'd2;
        else                               pop_n = 2'd1;
    end

    // Read word in the current format.
    always_comb begin
        fmt = '0;
        if (!empty) begin
            if (mode) fmt = {4'b0000, head0[ENTRY_W-1:CHAR_W], head0[CHAR_W-1:0]};
            else      fmt = {(pop_n == 2'd2) ? head1[CHAR_W-1:0] : 8'h00, head0[CHAR_W-1:0]};
        end
    end

    // Read data register.
    always_ff @(posedge clk) begin
        if (!rst_n || (rd_req && cnt_reset)) rd_data <= '0;
        else if (rd_req)                     rd_data <= fmt;
    end

    // Sticky events from this cycle's character.
    always_comb begin
        set_bits         = '0;
        set_bits[SK_PAR] = push_ok && fl.par;
        set_bits[SK_FRM] = push_ok && fl.frm;
        set_bits[SK_BRK] = push_ok && fl.brk;
        set_bits[SK_M1]  = push_ok && in_match[0];
        set_bits[SK_M2]  = push_ok && in_match[1];
        set_bits[SK_OVF] = push_drop;
    end

    rxq_store #(.DEPTH(DEPTH), .DW(ENTRY_W)) store_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (cnt_reset),
        .push      (push_ok),
        .push_word ({in_flags, in_data}),
        .pop_n     (pop_n),
        .count     (rx_count),
        .head0     (head0),
        .head1     (head1)
    );

    rxq_trigger #(.DEPTH(DEPTH)) trig_i (
        .sel   (trig_sel),
        .count (rx_count),
        .hit   (trig_hit)
    );

    rxq_status stat_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_wr    (stat_wr),
        .mode_val   (stat_wdata[15]),
        .set_bits   (set_bits),
        .clr_sticky (stat_rd && stat_rd_word),
        .levels     ({cts_in, dsr_in, cd_in, tx_fifo_empty, tx_shift_empty}),
        .rda        (!empty),
        .mode       (mode),
        .word       (stat_word)
    );
endmodule

// File: rtl/rxq_status_fifo_chk.sv
// Port-level checker for rxq_status_fifo, attached by bind below.
module rxq_status_fifo_chk #(
    parameter int DEPTH = 1023,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          in_valid,
    input logic          cnt_reset,
    input logic          rd_req,
    input logic          stat_rd,
    input logic          stat_rd_word,
    input logic [1:0]    trig_sel,
    input logic          trig_hit,
    input logic [CW-1:0] rx_count,
    input logic [15:0]   rd_data,
    input logic [15:0]   stat_word
);
    assert_count_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rx_count <= CW'(DEPTH));

    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !cnt_reset && rx_count == CW'(DEPTH)) |=> stat_word[13]);

    assert_full_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !cnt_reset && !rd_req && rx_count == CW'(DEPTH)) |=> rx_count == CW'(DEPTH));

    assert_empty_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !in_valid && !cnt_reset && rx_count == '0) |=> (rd_data == 16'h0 && rx_count == '0));

    assert_sticky_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd && stat_rd_word && !in_valid) |=> stat_word[13:8] == 6'b0);

    assert_rda_R8: assert property (@(posedge clk) disable iff (!rst_n)
        stat_word[0] == (rx_count != '0));

    assert_trig_one_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_sel == 2'b01) |-> (trig_hit == (rx_count != '0)));

    assert_flush_R10: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_reset |=> rx_count == '0);
endmodule

bind rxq_status_fifo rxq_status_fifo_chk #(.DEPTH(DEPTH)) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_valid     (in_valid),
    .cnt_reset    (cnt_reset),
    .rd_req       (rd_req),
    .stat_rd      (stat_rd),
    .stat_rd_word (stat_rd_word),
    .trig_sel     (trig_sel),
    .trig_hit     (trig_hit),
    .rx_count     (rx_count),
    .rd_data      (rd_data),
    .stat_word    (stat_word)
);

// File: tb/rxq_status_fifo_tb_top.sv
// Directed bench: inputs change and outputs are sampled on the falling edge.
module rxq_status_fifo_tb_top;
    localparam int DEPTH = 1023;
    localparam int CW    = $clog2(DEPTH + 1);

    logic          clk = 1'b0;
    logic          rst_n;
    logic          in_valid;
    logic [7:0]    in_data;
    logic [3:0]    in_flags;
    logic [1:0]    in_match;
    logic          cnt_reset;
    logic          rd_req;
    logic [15:0]   rd_data;
    logic [CW-1:0] rx_count;
    logic [1:0]    trig_sel;
    logic          trig_hit;
    logic          stat_wr;
    logic [15:0]   stat_wdata;
    logic          stat_rd;
    logic          stat_rd_word;
    logic [15:0]   stat_word;
    logic          cts_in, dsr_in, cd_in, tx_fifo_empty, tx_shift_empty;

    int checks   = 0;
    int failures = 0;

    always #5 clk = ~clk;

    rxq_status_fifo #(.DEPTH(DEPTH)) dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .in_flags(in_flags), .in_match(in_match), .cnt_reset(cnt_reset),
        .rd_req(rd_req), .rd_data(rd_data), .rx_count(rx_count),
        .trig_sel(trig_sel), .trig_hit(trig_hit), .stat_wr(stat_wr),
        .stat_wdata(stat_wdata), .stat_rd(stat_rd), .stat_rd_word(stat_rd_word),
        .stat_word(stat_word), .cts_in(cts_in), .dsr_in(dsr_in), .cd_in(cd_in),
        .tx_fifo_empty(tx_fifo_empty), .tx_shift_empty(tx_shift_empty)
    );

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    task automatic push(input logic [7:0] d, input logic [3:0] f, input logic [1:0] m);
        in_valid = 1'b1; in_data = d; in_flags = f; in_match = m;
        @(negedge clk);
        in_valid = 1'b0; in_flags = '0; in_match = '0;
    endtask

    task automatic do_read();
        rd_req = 1'b1;
        @(negedge clk);
        rd_req = 1'b0;
    endtask

    task automatic set_mode(input logic m);
        stat_wr = 1'b1; stat_wdata = {m, 15'h0};
        @(negedge clk);
        stat_wr = 1'b0;
    endtask

    task automatic t_reset();
        trig_sel = 2'b01;
        chk("R1", "count", 32'(rx_count), 0);
        chk("R1", "rd_data", 32'(rd_data), 0);
        chk("R1", "stat_word", 32'(stat_word), 0);
        chk("R1", "trig_hit", 32'(trig_hit), 0);
    endtask

    task automatic t_packed();
        push(8'hA1, 4'h0, 2'b00);
        push(8'hB2, 4'h0, 2'b00);
        push(8'hC3, 4'h0, 2'b00);
        chk("R2", "count after 3", 32'(rx_count), 3);
        do_read();
        chk("R4", "pair word", 32'(rd_data), 32'hB2A1);
        chk("R4", "count after pair", 32'(rx_count), 1);
        do_read();
        chk("R4", "single word", 32'(rd_data), 32'h00C3);
        do_read();
        chk("R6", "empty word", 32'(rd_data), 0);
        chk("R6", "empty count", 32'(rx_count), 0);
    endtask

    task automatic t_status_mode();
        set_mode(1'b1);
        chk("R5", "mode bit", 32'(stat_word[15]), 1);
        push(8'h55, 4'h9, 2'b00);
        push(8'h66, 4'h2, 2'b00);
        do_read();
        chk("R5", "first interleaved", 32'(rd_data), 32'h0955);
        chk("R5", "one removed", 32'(rx_count), 1);
        do_read();
        chk("R5", "second interleaved", 32'(rd_data), 32'h0266);
        set_mode(1'b0);
    endtask

    task automatic t_sticky();
        chk("R7", "brk+par sticky", 32'(stat_word[13:8]), 32'h05);
        push(8'h11, 4'h4, 2'b11);
        do_read();
        chk("R7", "all error+match sticky", 32'(stat_word[13:8]), 32'h1F);
        stat_rd = 1'b1; stat_rd_word = 1'b0;
        @(negedge clk);
        stat_rd = 1'b0;
        chk("R8", "low-byte read keeps sticky", 32'(stat_word[13:8]), 32'h1F);
        stat_rd = 1'b1; stat_rd_word = 1'b1;
        @(negedge clk);
        stat_rd = 1'b0; stat_rd_word = 1'b0;
        chk("R7", "cleared by word read", 32'(stat_word[13:8]), 0);
        stat_rd = 1'b1; stat_rd_word = 1'b1;
        push(8'h22, 4'h1, 2'b00);
        stat_rd = 1'b0; stat_rd_word = 1'b0;
        chk("R7", "set beats clear", 32'(stat_word[13:8]), 32'h01);
        do_read();
        chk("R8", "rda low when empty", 32'(stat_word[0]), 0);
        cts_in = 1'b1; cd_in = 1'b1; tx_shift_empty = 1'b1;
        @(negedge clk);
        chk("R8", "levels cts/cd/txse", 32'(stat_word[7:0]), 32'h2A);
        cts_in = 1'b0; cd_in = 1'b0; tx_shift_empty = 1'b0;
        dsr_in = 1'b1; tx_fifo_empty = 1'b1;
        push(8'h01, 4'h0, 2'b00);
        chk("R8", "levels dsr/txfe/rda", 32'(stat_word[7:0]), 32'h15);
        dsr_in = 1'b0; tx_fifo_empty = 1'b0;
        do_read();
    endtask

    task automatic t_flush();
        push(8'h31, 4'h0, 2'b00);
        push(8'h32, 4'h0, 2'b00);
        push(8'h33, 4'h0, 2'b00);
        cnt_reset = 1'b1; in_valid = 1'b1; in_data = 8'h99;
        @(negedge clk);
        cnt_reset = 1'b0; in_valid = 1'b0;
        chk("R10", "count after reset cmd", 32'(rx_count), 0);
        do_read();
        chk("R10", "read after reset cmd", 32'(rd_data), 0);
        push(8'h77, 4'h0, 2'b00);
        do_read();
        chk("R10", "first byte after reset cmd", 32'(rd_data), 32'h0077);
    endtask

    task automatic t_simul();
        push(8'h41, 4'h0, 2'b00);
        push(8'h42, 4'h0, 2'b00);
        rd_req = 1'b1;
        push(8'h43, 4'h0, 2'b00);
        rd_req = 1'b0;
        chk("R11", "word with concurrent push", 32'(rd_data), 32'h4241);
        chk("R11", "count with concurrent push", 32'(rx_count), 1);
        do_read();
        chk("R11", "pushed byte later", 32'(rd_data), 32'h0043);
    endtask

    task automatic t_fill_trigger_full();
        int bad;
        for (int i = 0; i < 511; i++) push(8'(i), 4'h0, 2'b00);
        trig_sel = 2'b10;
        @(negedge clk);
        chk("R9", "half below edge", 32'(trig_hit), 0);
        push(8'(511), 4'h0, 2'b00);
        chk("R9", "half at edge", 32'(trig_hit), 1);
        trig_sel = 2'b11;
        for (int i = 512; i < 895; i++) push(8'(i), 4'h0, 2'b00);
        chk("R9", "7/8 below edge", 32'(trig_hit), 0);
        push(8'(895), 4'h0, 2'b00);
        chk("R9", "7/8 at edge", 32'(trig_hit), 1);
        trig_sel = 2'b00;
        @(negedge clk);
        chk("R9", "off never", 32'(trig_hit), 0);
        trig_sel = 2'b01;
        for (int i = 896; i < DEPTH; i++) push(8'(i), 4'h0, 2'b00);
        chk("R2", "full count", 32'(rx_count), DEPTH);
        push(8'hEE, 4'h0, 2'b00);
        chk("R3", "count held when full", 32'(rx_count), DEPTH);
        chk("R3", "overflow flag", 32'(stat_word[13]), 1);
        bad = 0;
        for (int i = 0; i < (DEPTH - 1) / 2; i++) begin
            do_read();
            if (rd_data !== {8'(2 * i + 1), 8'(2 * i)}) bad++;
        end
        chk("R2", "order through drain", 32'(bad), 0);
        do_read();
        chk("R3", "last byte is not the dropped one", 32'(rd_data), 32'h00FE);
        chk("R2", "empty after drain", 32'(rx_count), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        rst_n = 1'b0; in_valid = 1'b0; in_data = '0; in_flags = '0; in_match = '0;
        cnt_reset = 1'b0; rd_req = 1'b0; trig_sel = 2'b00; stat_wr = 1'b0;
        stat_wdata = '0; stat_rd = 1'b0; stat_rd_word = 1'b0;
        cts_in = 1'b0; dsr_in = 1'b0; cd_in = 1'b0;
        tx_fifo_empty = 1'b0; tx_shift_empty = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_packed();
        t_status_mode();
        t_sticky();
        t_flush();
        t_simul();
        t_fill_trigger_full();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule